// File: doc/BRIEF.md
# Flash Page Permission Guard

This block judges whether a flash operation may proceed. A request names an operation (read, program or erase), an erase kind (single page or whole bank), a page number and a bank. One clock later the guard answers with a permit or deny. On a deny it records the page and bank it refused, so that status logic can report the failure.

Permissions come from eight page-granular windows, a fallback default, and a per-bank switch. Each window has an enable, a base page, a length in pages, and separate read, program and erase grants. The fallback applies to pages that no enabled window covers. A whole-bank erase ignores the windows and depends only on that bank's switch.

Each window and each bank switch carries a lock. The lock starts open after reset and can only be closed. Once it is closed, the configuration it protects stays frozen until the next reset. The bus decoder and the flash engine sit outside this block.

Top module: `flash_mp_guard`

## Requirements
- R1: After reset every window and bank lock reads open (`rgn_unlocked` all ones, `bank_unlocked` all ones), every window is disabled, the default grants nothing, every bank switch is off, `resp_valid` is 0 and `err_page`/`err_bank` are 0.
- R2: An enabled window covers page p when base <= p < base + size. The sum is taken one bit wider than the page, so it never wraps. A window of size 0 covers nothing.
- R3: For a read (`req_op`=0), a program (`req_op`=1) or a page erase (`req_op`=2, `req_bank_erase`=0), a page covered by an enabled window is permitted exactly when that window grants the matching right. A disabled window never covers a page.
- R4: When several enabled windows cover the page, the one with the lowest index alone decides.
- R5: A page that no enabled window covers takes the matching right from the default grants.
- R6: A bank erase (`req_op`=2, `req_bank_erase`=1) is permitted exactly when the erase switch of `req_bank` is set. Windows and the default play no part.
- R7: Pulsing `rgn_lock_clr` closes the lock of window `rgn_sel` for good. From the next cycle on, writes to that window are ignored. A write in the same cycle as the close still lands. Other windows stay writable.
- R8: Pulsing `bank_lock_clr` closes the lock of bank `bank_sel` for good. From the next cycle on, writes to that bank's switch are ignored.
- R9: A request taken at a clock edge produces `resp_valid`=1 for exactly one cycle after that edge, with `resp_allow` giving the verdict. With no request, `resp_valid` and `resp_allow` are 0.
- R10: On a deny, `err_page` and `err_bank` take the request's page and bank in the same cycle as the response. Permitted requests leave them unchanged.
- R11: The reserved operation code `req_op`=3 is always denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rgn_wr | input | 1 | Write window `rgn_sel` with the `rgn_w_*` fields |
| rgn_sel | input | 3 | Window index for write and lock close |
| rgn_lock_clr | input | 1 | Close the lock of window `rgn_sel` |
| rgn_w_en | input | 1 | Window enable value |
| rgn_w_rd | input | 1 | Read grant value |
| rgn_w_prog | input | 1 | Program grant value |
| rgn_w_erase | input | 1 | Page erase grant value |
| rgn_w_base | input | 9 | First page of the window |
| rgn_w_size | input | 9 | Window length in pages |
| dflt_wr | input | 1 | Write the default grants |
| dflt_w_rd | input | 1 | Default read grant |
| dflt_w_prog | input | 1 | Default program grant |
| dflt_w_erase | input | 1 | Default page erase grant |
| bank_wr | input | 1 | Write the erase switch of bank `bank_sel` |
| bank_sel | input | 1 | Bank index for write and lock close |
| bank_lock_clr | input | 1 | Close the lock of bank `bank_sel` |
| bank_w_erase | input | 1 | Bank erase switch value |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| req_bank_erase | input | 1 | With erase: 1 whole bank, 0 single page |
| req_page | input | 9 | Target page |
| req_bank | input | 1 | Target bank |
| resp_valid | output | 1 | Verdict present |
| resp_allow | output | 1 | 1 permit, 0 deny |
| err_page | output | 9 | Page of the last denied request |
| err_bank | output | 1 | Bank of the last denied request |
| rgn_unlocked | output | 8 | Per-window lock state, 1 open |
| bank_unlocked | output | 2 | Per-bank lock state, 1 open |

## Verification
The bench probes a window at its edges: one page below the base, the base itself, the last page, and one past the end. It also probes a zero-size window and a window near the top of the page range, which tells a sum taken one bit wider apart from a wrapping one.

Overlapping windows with conflicting grants show whether the lowest index wins and whether a disabled window is skipped. Uncovered pages show whether the default applies. A bank erase is sent to a page whose window forbids erase, which shows that the bank switch alone decides.

Writes after a lock closes are checked through later verdicts. Neighbouring windows and banks are written in the same test to show that only the locked one is frozen.

// File: rtl/flash_mp_pkg.sv
package flash_mp_pkg;
  parameter int MP_PAGE_W = 9;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } mp_op_e;

  typedef struct packed {
    logic                 en;
    logic                 rd;
    logic                 prog;
    logic                 erase;
    logic [MP_PAGE_W-1:0] base;
    logic [MP_PAGE_W-1:0] size;
  } mp_region_t;

  // Window coverage: base <= page < base + size, end computed one bit wider.
  function automatic logic page_hits(input logic [MP_PAGE_W-1:0] base,
                                     input logic [MP_PAGE_W-1:0] size,
                                     input logic [MP_PAGE_W-1:0] page);
    logic [MP_PAGE_W:0] stop;
    stop = {1'b0, base} + {1'b0, size};
    return (page >= base) && ({1'b0, page} < stop);
  endfunction

  // Select the grant matching the operation; bank erase handled elsewhere.
  function automatic logic grant_for(input mp_op_e op, input logic rd,
                                     input logic prog, input logic erase);
    case (op)
      OP_READ:  return rd;
      OP_PROG:  return prog;
      OP_ERASE: return erase;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/flash_mp_region.sv
module flash_mp_region
  import flash_mp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic                 lock_clr,
  input  mp_region_t           wcfg,
  input  logic [MP_PAGE_W-1:0] page,
  output mp_region_t           cfg_q,
  output logic                 unlocked,
  output logic                 hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      unlocked <= 1'b1;
    end else begin
      if (wr && unlocked) cfg_q <= wcfg;
      if (lock_clr)       unlocked <= 1'b0;
    end
  end

  assign hit = cfg_q.en && page_hits(cfg_q.base, cfg_q.size, page);
endmodule

// File: rtl/flash_mp_bank.sv
module flash_mp_bank (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic lock_clr,
  input  logic wen,
  output logic erase_en,
  output logic unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_en <= 1'b0;
      unlocked <= 1'b1;
    end else begin
      if (wr && unlocked) erase_en <= wen;
      if (lock_clr)       unlocked <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_mp_pick.sv
module flash_mp_pick
  import flash_mp_pkg::*;
#(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  input  mp_region_t       cfg [N],
  output logic             found,
  output mp_region_t       win,
  output logic [IDX_W-1:0] win_idx
);
  // Scan from the top index down so the lowest covering index is kept last.
  always_comb begin
    found   = 1'b0;
    win     = '0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found   = 1'b1;
        win     = cfg[i];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/flash_mp_guard.sv
module flash_mp_guard
  import flash_mp_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_BANKS   = 2,
  localparam int RSEL_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rgn_wr,
  input  logic [RSEL_W-1:0]      rgn_sel,
  input  logic                   rgn_lock_clr,
  input  logic                   rgn_w_en,
  input  logic                   rgn_w_rd,
  input  logic                   rgn_w_prog,
  input  logic                   rgn_w_erase,
  input  logic [MP_PAGE_W-1:0]   rgn_w_base,
  input  logic [MP_PAGE_W-1:0]   rgn_w_size,
  input  logic                   dflt_wr,
  input  logic                   dflt_w_rd,
  input  logic                   dflt_w_prog,
  input  logic                   dflt_w_erase,
  input  logic                   bank_wr,
  input  logic [BANK_W-1:0]      bank_sel,
  input  logic                   bank_lock_clr,
  input  logic                   bank_w_erase,
  input  logic                   req_valid,
  input  logic [1:0]             req_op,
  input  logic                   req_bank_erase,
  input  logic [MP_PAGE_W-1:0]   req_page,
  input  logic [BANK_W-1:0]      req_bank,
  output logic                   resp_valid,
  output logic                   resp_allow,
  output logic [MP_PAGE_W-1:0]   err_page,
  output logic [BANK_W-1:0]      err_bank,
  output logic [NUM_REGIONS-1:0] rgn_unlocked,
  output logic [NUM_BANKS-1:0]   bank_unlocked
);
  localparam int CFGW = $bits(mp_region_t);

  mp_region_t                    wcfg;
  mp_region_t                    rgn_cfg [NUM_REGIONS];
  logic [NUM_REGIONS-1:0]        rgn_hit;
  logic [NUM_REGIONS*CFGW-1:0]   rgn_cfg_flat;
  logic [NUM_BANKS-1:0]          bank_erase_en;
  logic                          rgn_found;
  mp_region_t                    rgn_win;
  logic [RSEL_W-1:0]             rgn_win_idx;
  logic                          dflt_rd, dflt_prog, dflt_erase;
  mp_op_e                        op;
  logic                          is_bank_erase;
  logic                          verdict;

  assign wcfg = '{en: rgn_w_en, rd: rgn_w_rd, prog: rgn_w_prog,
                  erase: rgn_w_erase, base: rgn_w_base, size: rgn_w_size};

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_rgn
    flash_mp_region u_rgn (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (rgn_wr && (rgn_sel == RSEL_W'(i))),
      .lock_clr (rgn_lock_clr && (rgn_sel == RSEL_W'(i))),
      .wcfg     (wcfg),
      .page     (req_page),
      .cfg_q    (rgn_cfg[i]),
      .unlocked (rgn_unlocked[i]),
      .hit      (rgn_hit[i])
    );
    assign rgn_cfg_flat[i*CFGW +: CFGW] = rgn_cfg[i];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    flash_mp_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (bank_wr && (bank_sel == BANK_W'(b))),
      .lock_clr (bank_lock_clr && (bank_sel == BANK_W'(b))),
      .wen      (bank_w_erase),
      .erase_en (bank_erase_en[b]),
      .unlocked (bank_unlocked[b])
    );
  end

  flash_mp_pick #(.N(NUM_REGIONS), .IDX_W(RSEL_W)) u_pick (
    .hits    (rgn_hit),
    .cfg     (rgn_cfg),
    .found   (rgn_found),
    .win     (rgn_win),
    .win_idx (rgn_win_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dflt_rd    <= 1'b0;
      dflt_prog  <= 1'b0;
      dflt_erase <= 1'b0;
    end else if (dflt_wr) begin
      dflt_rd    <= dflt_w_rd;
      dflt_prog  <= dflt_w_prog;
      dflt_erase <= dflt_w_erase;
    end
  end

  assign op            = mp_op_e'(req_op);
  assign is_bank_erase = (op == OP_ERASE) && req_bank_erase;

  always_comb begin
    if (is_bank_erase)   verdict = bank_erase_en[req_bank];
    else if (rgn_found)  verdict = grant_for(op, rgn_win.rd, rgn_win.prog, rgn_win.erase);
    else                 verdict = grant_for(op, dflt_rd, dflt_prog, dflt_erase);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      err_page   <= '0;
      err_bank   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= req_valid && verdict;
      if (req_valid && !verdict) begin
        err_page <= req_page;
        err_bank <= req_bank;
      end
    end
  end
endmodule

// File: rtl/flash_mp_guard_chk.sv
module flash_mp_guard_chk
  import flash_mp_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int NUM_BANKS   = 2,
  localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CFGW       = $bits(mp_region_t)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [1:0]                  req_op,
  input logic                        req_bank_erase,
  input logic [MP_PAGE_W-1:0]        req_page,
  input logic [BANK_W-1:0]           req_bank,
  input logic                        resp_valid,
  input logic                        resp_allow,
  input logic [MP_PAGE_W-1:0]        err_page,
  input logic [BANK_W-1:0]           err_bank,
  input logic [NUM_REGIONS-1:0]      rgn_unlocked,
  input logic [NUM_BANKS-1:0]        bank_unlocked,
  input logic [NUM_BANKS-1:0]        bank_erase_en,
  input logic [NUM_REGIONS*CFGW-1:0] rgn_cfg_flat
);
  a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  a_r9_no_req_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!resp_valid && !resp_allow));
  a_r10_deny_records: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_allow) |->
      (err_page == $past(req_page) && err_bank == $past(req_bank)));
  a_r10_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && !resp_allow) |-> ($stable(err_page) && $stable(err_bank)));
  a_r7_rgn_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rgn_unlocked & ~$past(rgn_unlocked)) == '0));
  a_r8_bank_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bank_unlocked & ~$past(bank_unlocked)) == '0));
  a_r6_bank_erase_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_op == 2'd2 && req_bank_erase)) |->
      (resp_allow == $past(bank_erase_en[req_bank])));
  a_r11_reserved_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && $past(req_op) == 2'd3) |-> !resp_allow);

  for (genvar k = 0; k < NUM_REGIONS; k++) begin : g_frozen
    a_r7_locked_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !rgn_unlocked[k] |=> $stable(rgn_cfg_flat[k*CFGW +: CFGW]));
  end
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bfrozen
    a_r8_locked_bank_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_unlocked[b] |=> $stable(bank_erase_en[b]));
  end
endmodule

bind flash_mp_guard flash_mp_guard_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .NUM_BANKS   (NUM_BANKS)
) u_chk (.*);

// File: tb/flash_mp_guard_test.sv
`timescale 1ns/1ps
module flash_mp_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rgn_wr = 0, rgn_lock_clr = 0;
  logic [2:0] rgn_sel = 0;
  logic       rgn_w_en = 0, rgn_w_rd = 0, rgn_w_prog = 0, rgn_w_erase = 0;
  logic [8:0] rgn_w_base = 0, rgn_w_size = 0;
  logic       dflt_wr = 0, dflt_w_rd = 0, dflt_w_prog = 0, dflt_w_erase = 0;
  logic       bank_wr = 0, bank_lock_clr = 0, bank_w_erase = 0;
  logic       bank_sel = 0;
  logic       req_valid = 0, req_bank_erase = 0, req_bank = 0;
  logic [1:0] req_op = 0;
  logic [8:0] req_page = 0;
  logic       resp_valid, resp_allow, err_bank;
  logic [8:0] err_page;
  logic [7:0] rgn_unlocked;
  logic [1:0] bank_unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_mp_guard uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_rgn(input int idx, input bit en, input bit rd, input bit pr,
                        input bit er, input int base, input int size);
    @(negedge clk);
    rgn_wr = 1; rgn_sel = 3'(idx); rgn_w_en = en; rgn_w_rd = rd;
    rgn_w_prog = pr; rgn_w_erase = er; rgn_w_base = 9'(base); rgn_w_size = 9'(size);
    @(negedge clk);
    rgn_wr = 0;
  endtask

  task automatic wr_bank(input int b, input bit en);
    @(negedge clk);
    bank_wr = 1; bank_sel = b[0]; bank_w_erase = en;
    @(negedge clk);
    bank_wr = 0;
  endtask

  // Request at one negedge, verdict sampled at the next negedge.
  task automatic do_req(input int op, input bit be, input int page, input bit bank,
                        input bit exp_allow, input string req);
    @(negedge clk);
    req_valid = 1; req_op = 2'(op); req_bank_erase = be;
    req_page = 9'(page); req_bank = bank;
    @(negedge clk);
    req_valid = 0;
    check({req, " valid"}, 32'(resp_valid), 32'd1);
    check({req, " allow"}, 32'(resp_allow), 32'(exp_allow));
    if (!exp_allow) begin
      check({req, " R10 err_page"}, 32'(err_page), 32'(page));
      check({req, " R10 err_bank"}, 32'(err_bank), 32'(bank));
    end
  endtask

  task automatic t_reset;
    check("R1 resp_valid", 32'(resp_valid), 0);
    check("R1 err_page", 32'(err_page), 0);
    check("R1 rgn_unlocked", 32'(rgn_unlocked), 32'hff);
    check("R1 bank_unlocked", 32'(bank_unlocked), 3);
    do_req(0, 0, 5, 0, 0, "R1 read denied at reset");
    do_req(2, 1, 6, 1, 0, "R1 bank erase denied at reset");
    @(negedge clk);
    check("R9 single cycle response", 32'(resp_valid), 0);
  endtask

  task automatic t_match;
    wr_rgn(2, 1, 1, 0, 0, 10, 4);
    do_req(0, 0, 9, 0, 0, "R2 below base");
    do_req(0, 0, 10, 0, 1, "R2 at base");
    do_req(0, 0, 13, 0, 1, "R2 last page");
    do_req(0, 0, 14, 0, 0, "R2 past end");
    do_req(1, 0, 11, 0, 0, "R3 program not granted");
    wr_rgn(3, 1, 1, 1, 1, 20, 0);
    do_req(0, 0, 20, 0, 0, "R2 zero size");
    wr_rgn(4, 1, 1, 0, 0, 510, 5);
    do_req(0, 0, 511, 0, 1, "R2 top page no wrap");
    do_req(0, 0, 0, 0, 0, "R2 page zero not covered");
  endtask

  task automatic t_priority;
    wr_rgn(0, 0, 1, 1, 1, 100, 10);
    wr_rgn(1, 1, 0, 1, 0, 100, 10);
    wr_rgn(5, 1, 1, 1, 1, 95, 20);
    do_req(0, 0, 105, 0, 0, "R4 lower index denies read");
    do_req(2, 0, 105, 0, 0, "R4 lower index denies page erase");
    do_req(1, 0, 105, 0, 1, "R4 lower index grants program");
    do_req(0, 0, 97, 0, 1, "R4 higher index alone");
  endtask

  task automatic t_default;
    @(negedge clk);
    dflt_wr = 1; dflt_w_rd = 1; dflt_w_prog = 0; dflt_w_erase = 1;
    @(negedge clk);
    dflt_wr = 0;
    do_req(0, 0, 300, 1, 1, "R5 default read");
    check("R10 err held after permit", 32'(err_page), 105);
    do_req(1, 0, 300, 1, 0, "R5 default program");
    do_req(2, 0, 300, 0, 1, "R5 default page erase");
    do_req(0, 0, 105, 0, 0, "R5 window overrides default");
  endtask

  task automatic t_bank_erase;
    wr_bank(0, 1);
    do_req(2, 1, 105, 0, 1, "R6 bank0 erase allowed");
    do_req(2, 1, 301, 1, 0, "R6 bank1 erase denied");
    do_req(2, 0, 300, 1, 1, "R6 page erase ignores bank switch");
  endtask

  task automatic t_reserved;
    do_req(3, 0, 97, 0, 0, "R11 reserved op");
    do_req(3, 1, 300, 0, 0, "R11 reserved op default");
  endtask

  task automatic t_region_lock;
    @(negedge clk);
    rgn_lock_clr = 1; rgn_sel = 3'd2;
    @(negedge clk);
    rgn_lock_clr = 0;
    check("R7 lock closed", 32'(rgn_unlocked), 32'hfb);
    wr_rgn(2, 1, 1, 1, 0, 10, 4);
    do_req(1, 0, 11, 0, 0, "R7 locked write ignored");
    do_req(0, 0, 11, 0, 1, "R7 locked config kept");
    wr_rgn(6, 1, 0, 1, 0, 200, 1);
    do_req(1, 0, 200, 0, 1, "R7 other window writable");
    // close and write together: write lands
    @(negedge clk);
    rgn_lock_clr = 1; rgn_wr = 1; rgn_sel = 3'd7; rgn_w_en = 1; rgn_w_rd = 1;
    rgn_w_prog = 0; rgn_w_erase = 0; rgn_w_base = 9'd400; rgn_w_size = 9'd2;
    @(negedge clk);
    rgn_lock_clr = 0; rgn_wr = 0;
    check("R7 same cycle lock", 32'(rgn_unlocked), 32'h7b);
    do_req(0, 0, 401, 0, 1, "R7 same cycle write landed");
  endtask

  task automatic t_bank_lock;
    @(negedge clk);
    bank_lock_clr = 1; bank_sel = 1'b1;
    @(negedge clk);
    bank_lock_clr = 0;
    check("R8 bank lock closed", 32'(bank_unlocked), 1);
    wr_bank(1, 1);
    do_req(2, 1, 50, 1, 0, "R8 locked bank write ignored");
    wr_bank(0, 0);
    do_req(2, 1, 50, 0, 0, "R8 open bank writable");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_match();
    t_priority();
    t_default();
    t_bank_erase();
    t_reserved();
    t_region_lock();
    t_bank_lock();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule